// File: doc/BRIEF.md
# Dynamic Element Matching Rotation Sequencer

This block produces the switch-control pattern for a cascade of current-divider stages that use dynamic element matching. In each stage, four nominally equal elements are moved across four port slots. Slots 0 and 1 both feed a port of weight 2, slot 2 feeds a unit port A and slot 3 feeds a unit port B. A circulating one-hot 4-bit register sets the assignment and steps once per enabled clock. After four enabled clocks, every element has occupied every slot for exactly one clock. Element mismatch therefore averages out over each cycle, and the leftover ripple sits at one quarter of the clock rate.

Five such stages run in lock step, as a binary-weighted network needs. Each stage has its own ring register and its own routing matrix. A behavioural check path goes with each stage. It takes signed integer mismatch values, one per element, and adds each value to a running total for the port that element currently drives. The totals show the averaging at work: over whole cycles, both unit ports collect the same amount, and the weight-2 port collects twice that amount.

Top module: `demRotationSequencer`

## Requirements
- R1: While `rstN` is low, every stage is in its start state: `routeMatrix` row k has only slot k set, all `portSum` values are zero and `wholeCycle` is high.
- R2: Let n be the number of enabled clocks since reset. Row k of a stage then has only bit (n+k) mod 4 set. Bit index `stage*16 + k*4 + slot` of `routeMatrix` means element k drives that slot.
- R3: In every stage's 4x4 matrix, each row and each column holds exactly one 1.
- R4: A clock with `enable` low changes neither the routing pattern, the `portSum` totals nor `wholeCycle`.
- R5: Slots map to ports as follows: slots 0 and 1 feed port 0 (the weight-2 port), slot 2 feeds port 1 and slot 3 feeds port 2. The total for port p of stage s appears at `portSum` index `s*3 + p` as a two's-complement value.
- R6: On each enabled clock, each element's signed two's-complement `mismatch` value (index `stage*4 + element`) is added to the total of the port it drives in the state before that edge.
- R7: `wholeCycle` is high exactly when n is a multiple of 4. With constant mismatch at such a point, ports 1 and 2 each hold n/4 times the element sum, and port 0 holds twice that. Mismatch that sums to zero therefore leaves all three totals at zero.
- R8: All five stages step on the same enable and show the same routing. Each stage totals only its own mismatch inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Advance rotation and accumulation this clock |
| mismatch | input | 160 | Signed per-element mismatch, 8 bits each, 5 stages x 4 elements |
| routeMatrix | output | 80 | One-hot routing rows, 5 stages x 4 elements x 4 slots |
| portSum | output | 300 | Signed per-port mismatch totals, 20 bits each, 5 stages x 3 ports |
| wholeCycle | output | 1 | High when the enabled-clock count is a multiple of four |

## Verification
Every output is a register. The routing, the totals and `wholeCycle` therefore all change on the same rising edge that samples an enable. The bench drives `enable` and `mismatch` on the falling edge and checks the outputs 1 ns after the following rising edge, and only there. At that point the bench has already counted that edge's enable into its own n, so every expected value refers to the state after the edge. The bench computes the expected totals from n and the held mismatch values by summing, for each slot, the element that stood there at each past step. While reset is held, the start state is checked before the first edge.

// File: rtl/demPkg.sv
package demPkg;
  localparam int ELEMS = 4;
  localparam int PORTS = 3;
  localparam int PH_W  = $clog2(ELEMS);

  typedef struct packed {
    logic advance;
    logic accumulate;
  } demStrobes_t;

  // slots 0 and 1 share the weight-2 port
  function automatic int slotPort(input int slot);
    return (slot < 2) ? 0 : slot - 1;
  endfunction
endpackage

// File: rtl/demCtrl.sv
module demCtrl
  import demPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  output demStrobes_t strb,
  output logic        wholeCycle
);
  logic [PH_W-1:0] phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= '0;
    else if (enable) phase <= phase + 1'b1;
  end

  always_comb begin
    strb.advance    = enable;
    strb.accumulate = enable;
    wholeCycle      = (phase == '0);
  end

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && phase == PH_W'(ELEMS-1)) |=> wholeCycle);
  // R4
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(wholeCycle));
endmodule

// File: rtl/demStage.sv
module demStage
  import demPkg::*;
#(
  parameter int MIS_W = 8,
  parameter int ACC_W = 20
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  demStrobes_t                  strb,
  input  logic [ELEMS-1:0][MIS_W-1:0]  mismatch,
  output logic [ELEMS-1:0][ELEMS-1:0]  route,
  output logic [PORTS-1:0][ACC_W-1:0]  portSum
);
  logic [ELEMS-1:0]       ring;
  logic [2*ELEMS-1:0]     ringDbl;
  logic [ELEMS-1:0]       colMask;
  logic signed [ACC_W-1:0] delta [PORTS];

  assign ringDbl = {ring, ring};

  genvar k;
  generate
    for (k = 0; k < ELEMS; k++) begin : g_row
      assign route[k] = ringDbl[2*ELEMS-1-k -: ELEMS];
    end
  endgenerate

  always_comb begin
    colMask = '0;
    for (int r = 0; r < ELEMS; r++) colMask = colMask | route[r];
  end

  always_comb begin
    for (int p = 0; p < PORTS; p++) delta[p] = '0;
    for (int e = 0; e < ELEMS; e++) begin
      for (int s = 0; s < ELEMS; s++) begin
        if (route[e][s])
          delta[slotPort(s)] = delta[slotPort(s)] + ACC_W'($signed(mismatch[e]));
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ring    <= ELEMS'(1);
      portSum <= '0;
    end else begin
      if (strb.advance) ring <= {ring[ELEMS-2:0], ring[ELEMS-1]};
      if (strb.accumulate)
        for (int p = 0; p < PORTS; p++) portSum[p] <= portSum[p] + delta[p];
    end
  end

  // R3
  ring_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(ring) == 1);
  // R3
  col_cover_chk: assert property (@(posedge clk) disable iff (!rstN)
    colMask == '1);
  // R4
  ring_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.advance |=> $stable(route));
  // R4
  sum_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.accumulate |=> $stable(portSum));
endmodule

// File: rtl/demDatapath.sv
module demDatapath
  import demPkg::*;
#(
  parameter int NUM_STAGES = 5,
  parameter int MIS_W      = 8,
  parameter int ACC_W      = 20
) (
  input  logic                                         clk,
  input  logic                                         rstN,
  input  demStrobes_t                                  strb,
  input  logic [NUM_STAGES-1:0][ELEMS-1:0][MIS_W-1:0]  mismatch,
  output logic [NUM_STAGES-1:0][ELEMS-1:0][ELEMS-1:0]  route,
  output logic [NUM_STAGES-1:0][PORTS-1:0][ACC_W-1:0]  portSum
);
  genvar st;
  generate
    for (st = 0; st < NUM_STAGES; st++) begin : g_stage
      demStage #(.MIS_W(MIS_W), .ACC_W(ACC_W)) stageInst (
        .clk      (clk),
        .rstN     (rstN),
        .strb     (strb),
        .mismatch (mismatch[st]),
        .route    (route[st]),
        .portSum  (portSum[st])
      );
    end
  endgenerate
endmodule

// File: rtl/demRotationSequencer.sv
module demRotationSequencer
  import demPkg::*;
#(
  parameter int NUM_STAGES = 5,
  parameter int MIS_W      = 8,
  parameter int ACC_W      = 20
) (
  input  logic                                         clk,
  input  logic                                         rstN,
  input  logic                                         enable,
  input  logic [NUM_STAGES-1:0][ELEMS-1:0][MIS_W-1:0]  mismatch,
  output logic [NUM_STAGES-1:0][ELEMS-1:0][ELEMS-1:0]  routeMatrix,
  output logic [NUM_STAGES-1:0][PORTS-1:0][ACC_W-1:0]  portSum,
  output logic                                         wholeCycle
);
  demStrobes_t strb;

  demCtrl ctrlInst (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .strb       (strb),
    .wholeCycle (wholeCycle)
  );

  demDatapath #(.NUM_STAGES(NUM_STAGES), .MIS_W(MIS_W), .ACC_W(ACC_W)) dpInst (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .mismatch (mismatch),
    .route    (routeMatrix),
    .portSum  (portSum)
  );

  genvar st;
  generate
    for (st = 0; st < NUM_STAGES; st++) begin : g_align
      // R7
      cycle_align_chk: assert property (@(posedge clk) disable iff (!rstN)
        wholeCycle |-> routeMatrix[st][0] == ELEMS'(1));
      // R8
      stage_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
        routeMatrix[st] == routeMatrix[0]);
    end
  endgenerate
endmodule

// File: tb/demRotationSequencer_test.sv
module demRotationSequencer_test;
  localparam int NS = 5;
  localparam int MW = 8;
  localparam int AW = 20;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, enable;
  logic [NS-1:0][3:0][MW-1:0] mis;
  logic [NS-1:0][3:0][3:0]    route;
  logic [NS-1:0][2:0][AW-1:0] sums;
  logic                       wholeCycle;

  int errors = 0;
  int checks = 0;
  int nEn = 0;
  logic [7:0] lfsr = 8'hA5;

  demRotationSequencer #(.NUM_STAGES(NS), .MIS_W(MW), .ACC_W(AW)) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .mismatch(mis),
    .routeMatrix(route), .portSum(sums), .wholeCycle(wholeCycle)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int mval(input int test, input int st, input int k);
    int s3;
    case (test)
      0: begin
        if (k < 3) return ((k*7 + st*3) % 11) - 5;
        s3 = 0;
        for (int j = 0; j < 3; j++) s3 += ((j*7 + st*3) % 11) - 5;
        return -s3;
      end
      1: return ((k*5 + st*2 + 1) % 13) - 4;
      default: begin
        if (k == 0) return 127;
        if (k == 1) return -128;
        if (k == 2) return 100 - st;
        return -st*9;
      end
    endcase
  endfunction

  // expected totals: the element standing in slot s at step t is (s - t) mod 4
  task automatic checkAll(input string req);
    for (int st = 0; st < NS; st++) begin
      logic [3:0] col;
      col = '0;
      for (int k = 0; k < 4; k++) begin
        logic [3:0] expRow;
        expRow = 4'b0001 << ((nEn + k) % 4);
        chk(route[st][k] == expRow, req, $sformatf("R2,R8 route stage %0d row %0d", st, k),
            route[st][k], expRow);
        col = col | route[st][k];
        chk($countones(route[st][k]) == 1, "R3", "row ones", $countones(route[st][k]), 1);
      end
      chk(col == 4'hF, "R3", $sformatf("column cover stage %0d", st), col, 15);
      for (int p = 0; p < 3; p++) begin
        longint expSum = 0;
        for (int t = 0; t < nEn; t++)
          for (int s = 0; s < 4; s++)
            if (((s < 2) ? 0 : s - 1) == p)
              expSum += longint'($signed(mis[st][(s - (t % 4) + 4) % 4]));
        chk(longint'($signed(sums[st][p])) == expSum, req,
            $sformatf("R5,R6 sum stage %0d port %0d", st, p),
            longint'($signed(sums[st][p])), expSum);
      end
    end
    chk(wholeCycle == ((nEn % 4) == 0), req, "R7 wholeCycle", wholeCycle, (nEn % 4) == 0);
  endtask

  task automatic doReset(input int test);
    @(negedge clk);
    rstN = 1'b0;
    enable = 1'b0;
    for (int st = 0; st < NS; st++)
      for (int k = 0; k < 4; k++) mis[st][k] = MW'(mval(test, st, k));
    nEn = 0;
    #2;
    checkAll("R1");
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic tick(input bit e);
    @(negedge clk);
    enable = e;
    @(posedge clk);
    #1;
    if (e) nEn++;
    if (!e) checkAll("R4");
    else if ((nEn % 4) == 0) checkAll("R7");
    else checkAll("R6");
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    enable = 1'b0;
    mis = '0;
    for (int test = 0; test < 3; test++) begin
      doReset(test);
      // one full cycle enabled back to back
      for (int i = 0; i < 4; i++) tick(1'b1);
      // hold in mid cycle
      tick(1'b1);
      for (int i = 0; i < 3; i++) tick(1'b0);
      // irregular enable pattern
      for (int i = 0; i < 40; i++) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        tick(lfsr[0] | lfsr[2]);
      end
      // close out to a whole cycle
      while ((nEn % 4) != 0) tick(1'b1);
      for (int i = 0; i < 8; i++) tick(1'b1);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule